// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM. The host presents one word at a time through a valid/ready handshake, with an address, a write flag and write data. The controller turns each request into a correctly timed sequence of active-low chip-enable, write-enable and output-enable strobes, a registered address, and a data bus that is split into output value, output-enable and input value. A read returns its word to the host as a one-cycle response pulse.

All memory timing limits are expressed in nanoseconds and selected by a speed-grade parameter. A second parameter gives the clock period. Each phase length is the ceiling of the governing limit divided by the clock period, and is never less than one cycle. Write-enable is always the strobe that ends a write, so data setup and hold are measured against its rising edge. After every read the controller waits out the memory's bus-release time before it accepts another request. This guarantees that its own data driver never fights the memory's output.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. While req_valid is 0 the strobes stay high and req_ready stays 1. req_ready is 1 only while all strobes are high.
- R3: For a write (req_write = 1), mem_ce_n and mem_we_n go low in the same cycle and stay low together for exactly N_WP = ceil(max(write pulse, chip-enable-to-end, address-to-end, data setup) / clock period) cycles. They then rise in the same cycle, so write-enable is the terminating edge.
- R4: A write keeps req_ready low for max(N_WC, N_WP + 1) cycles, where N_WC = ceil(write cycle / clock period). mem_addr does not change while mem_ce_n is low.
- R5: mem_dq_oe is 1 in exactly the busy cycles of a write, including the cycle in which mem_we_n rises. It is never 1 while mem_oe_n is 0. The value written is the req_wdata taken with the request.
- R6: For a read (req_write = 0), mem_ce_n and mem_oe_n are low for exactly N_RD = ceil(max(read cycle, address-to-data, output-enable-to-data) / clock period) cycles, and mem_we_n stays high.
- R7: mem_dq_i is captured at the edge that ends the last read cycle. It is returned on rsp_rdata with rsp_valid high for exactly one cycle, the first cycle after that edge.
- R8: After a read, N_HZ = ceil(bus release / clock period) cycles follow with all strobes high, req_ready low and mem_dq_oe 0. The full read therefore keeps req_ready low for N_RD + N_HZ cycles.
- R9: SPEED_GRADE = 0 selects write cycle 45, write pulse 35, chip-enable-to-end 35, address-to-end 35, data setup 25, read cycle 45, address-to-data 45, output-enable-to-data 22 and bus release 18 ns. SPEED_GRADE = 1 selects 55, 40, 40, 40, 25, 55, 55, 25 and 20 ns. Address setup and data hold are 0 ns in both grades.
- R10: Back-to-back requests are supported. If req_valid is held high, the next request is taken on the first edge at which req_ready is 1, with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | Address to memory |
| mem_dq_o | output | DW | Data driven toward memory |
| mem_dq_i | input | DW | Data returned by memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds two instances with a 4-bit address, 8-bit data and a 4 ns clock, one for each SPEED_GRADE value. With these settings the phase lengths differ between grades: a write pulse of 9 or 10 cycles, a write cycle of 12 or 14, and a read access of 12 or 14. The bus release is 5 cycles in both. On each instance, every address is written and read back. Strobe low times, busy lengths and response timing are compared with counts the bench computes itself from the nanosecond limits. Chained write-to-read and read-to-write pairs exercise back-to-back acceptance.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

   typedef struct packed {
      int wr_cycle;
      int wr_pulse;
      int ce_to_end;
      int addr_to_end;
      int data_setup;
      int rd_cycle;
      int addr_to_data;
      int oe_to_data;
      int bus_release;
   } mem_timing_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WR_PULSE,
      PH_WR_TAIL,
      PH_RD_ACCESS,
      PH_RD_RELEASE
   } phase_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int ns_to_cycles(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic mem_timing_t grade_timing(input int grade);
      mem_timing_t t;
      if (grade == 0) begin
         t.wr_cycle     = 45;
         t.wr_pulse     = 35;
         t.ce_to_end    = 35;
         t.addr_to_end  = 35;
         t.data_setup   = 25;
         t.rd_cycle     = 45;
         t.addr_to_data = 45;
         t.oe_to_data   = 22;
         t.bus_release  = 18;
      end else begin
         t.wr_cycle     = 55;
         t.wr_pulse     = 40;
         t.ce_to_end    = 40;
         t.addr_to_end  = 40;
         t.data_setup   = 25;
         t.rd_cycle     = 55;
         t.addr_to_data = 55;
         t.oe_to_data   = 25;
         t.bus_release  = 20;
      end
      return t;
   endfunction

endpackage

// File: rtl/sram_phase_counter.sv
module sram_phase_counter #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R3 R6: a loaded phase never finishes in the cycle right after a load of a nonzero value
   a_r3_phase_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !done);

endmodule

// File: rtl/sram_dq_driver.sv
module sram_dq_driver #(
   parameter int DW   = 8,
   parameter int N_HZ = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_wdata,
   input  logic [DW-1:0] wdata,
   input  logic          drive_d,
   input  logic          mem_oe_n,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe
);

   localparam int HW = $clog2(N_HZ + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_o  <= '0;
         dq_oe <= 1'b0;
      end else begin
         if (take_wdata) dq_o <= wdata;
         dq_oe <= drive_d;
      end
   end

   // checker state: cycles that output enable has been high, saturating
   logic [HW-1:0] rel_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rel_q <= HW'(N_HZ);
      else if (!mem_oe_n)            rel_q <= '0;
      else if (rel_q != HW'(N_HZ))   rel_q <= rel_q + 1'b1;
   end

   // R5: never drive while the memory may drive
   a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> mem_oe_n);

   // R8: driver turns on only after the release window has elapsed
   a_r8_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (rel_q == HW'(N_HZ)));

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [DW-1:0] dq_i,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= dq_i;
      end
   end

   // R7: response is a single-cycle pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_strobe_pkg::*;
#(
   parameter int AW            = 18,
   parameter int DW            = 8,
   parameter int CLK_PERIOD_NS = 4,
   parameter int SPEED_GRADE   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   input  logic [DW-1:0] mem_dq_i,
   output logic          mem_dq_oe,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n
);

   localparam mem_timing_t TIM = grade_timing(SPEED_GRADE);

   localparam int N_WP   = ns_to_cycles(imax(imax(TIM.wr_pulse, TIM.ce_to_end),
                                             imax(TIM.addr_to_end, TIM.data_setup)),
                                        CLK_PERIOD_NS);
   localparam int N_WC   = ns_to_cycles(TIM.wr_cycle, CLK_PERIOD_NS);
   localparam int N_TAIL = imax(N_WC - N_WP, 1);
   localparam int N_RD   = ns_to_cycles(imax(TIM.rd_cycle, imax(TIM.addr_to_data, TIM.oe_to_data)),
                                        CLK_PERIOD_NS);
   localparam int N_HZ   = ns_to_cycles(TIM.bus_release, CLK_PERIOD_NS);
   localparam int N_MAX  = imax(imax(N_WP, N_TAIL), imax(N_RD, N_HZ));
   localparam int CW     = $clog2(N_MAX + 1);

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be at least 1");
      end
      if (SPEED_GRADE < 0 || SPEED_GRADE > 1) begin : g_bad_grade
         $error("SPEED_GRADE must be 0 or 1");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("AW and DW must be at least 1");
      end
   endgenerate

   phase_e        state_q, state_d;
   logic          cnt_load;
   logic [CW-1:0] cnt_val;
   logic          cnt_done;
   logic          accept;

   assign req_ready = (state_q == PH_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (state_q)
         PH_IDLE: begin
            if (req_valid) begin
               cnt_load = 1'b1;
               if (req_write) begin
                  state_d = PH_WR_PULSE;
                  cnt_val = CW'(N_WP - 1);
               end else begin
                  state_d = PH_RD_ACCESS;
                  cnt_val = CW'(N_RD - 1);
               end
            end
         end
         PH_WR_PULSE: begin
            if (cnt_done) begin
               state_d  = PH_WR_TAIL;
               cnt_load = 1'b1;
               cnt_val  = CW'(N_TAIL - 1);
            end
         end
         PH_WR_TAIL: begin
            if (cnt_done) state_d = PH_IDLE;
         end
         PH_RD_ACCESS: begin
            if (cnt_done) begin
               state_d  = PH_RD_RELEASE;
               cnt_load = 1'b1;
               cnt_val  = CW'(N_HZ - 1);
            end
         end
         PH_RD_RELEASE: begin
            if (cnt_done) state_d = PH_IDLE;
         end
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PH_IDLE;
         mem_ce_n <= 1'b1;
         mem_we_n <= 1'b1;
         mem_oe_n <= 1'b1;
         mem_addr <= '0;
      end else begin
         state_q  <= state_d;
         mem_ce_n <= !(state_d == PH_WR_PULSE || state_d == PH_RD_ACCESS);
         mem_we_n <= (state_d != PH_WR_PULSE);
         mem_oe_n <= (state_d != PH_RD_ACCESS);
         if (accept) mem_addr <= req_addr;
      end
   end

   sram_phase_counter #(.CW(CW)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .done     (cnt_done)
   );

   sram_dq_driver #(.DW(DW), .N_HZ(N_HZ)) u_driver (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_wdata (accept && req_write),
      .wdata      (req_wdata),
      .drive_d    (state_d == PH_WR_PULSE || state_d == PH_WR_TAIL),
      .mem_oe_n   (mem_oe_n),
      .dq_o       (mem_dq_o),
      .dq_oe      (mem_dq_oe)
   );

   sram_read_capture #(.DW(DW)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (state_q == PH_RD_ACCESS && cnt_done),
      .dq_i      (mem_dq_i),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   // checker state: length of the current write-enable low run
   logic [CW-1:0] wlow_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wlow_q <= '0;
      else if (!mem_we_n) wlow_q <= wlow_q + 1'b1;
      else                wlow_q <= '0;
   end

   // R2: ready only with all strobes idle
   a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

   // R3: write-enable low implies chip enable low
   a_r3_we_within_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);

   // R3: write ends on write-enable and chip enable rises with it
   a_r3_end_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_ce_n);

   // R3: write pulse length
   a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (wlow_q == CW'(N_WP)));

   // R4: address steady while the chip is selected
   a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R6: no write strobe during a read
   a_r6_read_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> mem_we_n);

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_lane #(
   parameter int GRADE = 0
) (
   input  logic clk,
   input  logic rst_n,
   output int   checks,
   output int   fails,
   output logic done
);

   localparam int AW  = 4;
   localparam int DW  = 8;
   localparam int CLK = 4;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // R9: limits per grade
   localparam int T_WC  = (GRADE == 0) ? 45 : 55;
   localparam int T_WP  = (GRADE == 0) ? 35 : 40;
   localparam int T_SD  = 25;
   localparam int T_RC  = (GRADE == 0) ? 45 : 55;
   localparam int T_AA  = (GRADE == 0) ? 45 : 55;
   localparam int T_DOE = (GRADE == 0) ? 22 : 25;
   localparam int T_HZ  = (GRADE == 0) ? 18 : 20;

   localparam int EWP   = cdiv(mx(T_WP, T_SD), CLK);
   localparam int EWBSY = mx(cdiv(T_WC, CLK), EWP + 1);
   localparam int ERD   = cdiv(mx(mx(T_RC, T_AA), T_DOE), CLK);
   localparam int EHZ   = cdiv(T_HZ, CLK);

   logic          req_valid, req_ready, req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o, mem_dq_i;
   logic          mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;

   sram_strobe_ctrl #(.AW(AW), .DW(DW), .CLK_PERIOD_NS(CLK), .SPEED_GRADE(GRADE)) u_sram_strobe_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
      .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
   );

   // memory model, sampled away from the clock edge
   logic [DW-1:0] mem [16];
   logic          prev_ce, prev_we;
   logic [AW-1:0] prev_addr;
   int            m_checks, m_fails, t_checks, t_fails;

   assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr] : '0;
   assign checks   = t_checks + m_checks;
   assign fails    = t_fails + m_fails;

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      prev_ce = 1'b1; prev_we = 1'b1; prev_addr = '0;
      m_checks = 0; m_fails = 0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!prev_we && !prev_ce && mem_we_n) begin
            m_checks++;
            if (!mem_dq_oe) begin
               m_fails++;
               $display("FAIL R5 grade %0d: driver off at write end, actual %0b expected 1", GRADE, mem_dq_oe);
            end
            if (!mem_ce_n) begin
               m_fails++;
               $display("FAIL R3 grade %0d: chip enable still low at write end, actual %0b expected 1", GRADE, mem_ce_n);
            end
            mem[prev_addr] = mem_dq_o;
         end
         if (!mem_oe_n && mem_dq_oe) begin
            m_checks++;
            m_fails++;
            $display("FAIL R5 grade %0d: drive during output enable, actual %0b expected 0", GRADE, mem_dq_oe);
         end
         if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) begin
            m_checks++;
            m_fails++;
            $display("FAIL R4 grade %0d: address moved, actual %0h expected %0h", GRADE, mem_addr, prev_addr);
         end
      end
      prev_ce   = mem_ce_n;
      prev_we   = mem_we_n;
      prev_addr = mem_addr;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      t_checks++;
      if (act != exp) begin
         t_fails++;
         $display("FAIL %s grade %0d %s: actual %0d expected %0d", req, GRADE, what, act, exp);
      end
   endtask

   task automatic do_op(input bit wr, input bit chain, input bit keep,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int busy, output int we_lo, output int ce_lo, output int oe_lo,
                        output int drv, output int rv_n, output int rv_idx, output int rd);
      busy = 0; we_lo = 0; ce_lo = 0; oe_lo = 0; drv = 0; rv_n = 0; rv_idx = -1; rd = -1;
      if (!chain) @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (!keep) req_valid = 1'b0;
      while (!req_ready && busy < 1000) begin
         if (!mem_we_n)  we_lo++;
         if (!mem_ce_n)  ce_lo++;
         if (!mem_oe_n)  oe_lo++;
         if (mem_dq_oe)  drv++;
         if (rsp_valid) begin rv_n++; rv_idx = busy; rd = int'(rsp_rdata); end
         busy++;
         @(negedge clk);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 37 + 11 + GRADE * 90) & 8'hFF);
   endfunction

   int busy, we_lo, ce_lo, oe_lo, drv, rv_n, rv_idx, rd, act_strobes;

   initial begin
      t_checks = 0; t_fails = 0; done = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      wait (rst_n);
      @(negedge clk);
      chk("R1", "ce_n", int'(mem_ce_n), 1);
      chk("R1", "we_n", int'(mem_we_n), 1);
      chk("R1", "oe_n", int'(mem_oe_n), 1);
      chk("R1", "dq_oe", int'(mem_dq_oe), 0);
      chk("R1", "rsp_valid", int'(rsp_valid), 0);
      chk("R1", "ready", int'(req_ready), 1);

      // R2: no request, nothing moves
      act_strobes = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe || !req_ready) act_strobes++;
      end
      chk("R2", "activity with valid low", act_strobes, 0);

      // writes across every address
      for (int a = 0; a < 16; a++) begin
         do_op(1'b1, 1'b0, 1'b0, AW'(a), pat(a), busy, we_lo, ce_lo, oe_lo, drv, rv_n, rv_idx, rd);
         chk("R3", "we low cycles", we_lo, EWP);
         chk("R3", "ce low cycles", ce_lo, EWP);
         chk("R4 R9", "write busy", busy, EWBSY);
         chk("R5", "driver cycles", drv, EWBSY);
         chk("R6", "oe low during write", oe_lo, 0);
      end

      // reads across every address
      for (int a = 0; a < 16; a++) begin
         do_op(1'b0, 1'b0, 1'b0, AW'(a), '0, busy, we_lo, ce_lo, oe_lo, drv, rv_n, rv_idx, rd);
         chk("R6 R9", "oe low cycles", oe_lo, ERD);
         chk("R6", "we low during read", we_lo, 0);
         chk("R7", "rsp pulses", rv_n, 1);
         chk("R7", "rsp cycle index", rv_idx, ERD);
         chk("R7 R5", "read data", rd, int'(pat(a)));
         chk("R8", "read busy", busy, ERD + EHZ);
         chk("R8", "driver during read", drv, 0);
      end

      // R10: write then read chained with valid held high
      do_op(1'b1, 1'b0, 1'b1, 4'd3, 8'h5A, busy, we_lo, ce_lo, oe_lo, drv, rv_n, rv_idx, rd);
      chk("R10", "chained write busy", busy, EWBSY);
      do_op(1'b0, 1'b1, 1'b1, 4'd3, '0, busy, we_lo, ce_lo, oe_lo, drv, rv_n, rv_idx, rd);
      chk("R10", "chained read busy", busy, ERD + EHZ);
      chk("R10", "chained read data", rd, 32'h5A);
      // R10: read then write chained
      do_op(1'b1, 1'b1, 1'b0, 4'd9, 8'hC3, busy, we_lo, ce_lo, oe_lo, drv, rv_n, rv_idx, rd);
      chk("R10", "chained write after read busy", busy, EWBSY);
      chk("R10", "chained write pulse", we_lo, EWP);
      do_op(1'b0, 1'b0, 1'b0, 4'd9, '0, busy, we_lo, ce_lo, oe_lo, drv, rv_n, rv_idx, rd);
      chk("R10", "read back after chain", rd, 32'hC3);

      done = 1'b1;
   end

endmodule

module sram_strobe_ctrl_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   c0, f0, c1, f1;
   logic d0, d1;
   int   extra_fail;

   always #2 clk = ~clk;

   sram_strobe_ctrl_lane #(.GRADE(0)) u_lane_fast (.clk(clk), .rst_n(rst_n), .checks(c0), .fails(f0), .done(d0));
   sram_strobe_ctrl_lane #(.GRADE(1)) u_lane_slow (.clk(clk), .rst_n(rst_n), .checks(c1), .fails(f1), .done(d1));

   initial begin
      extra_fail = 0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 150000; cyc++) begin
         @(negedge clk);
         if (d0 === 1'b1 && d1 === 1'b1) break;
      end
      if (!(d0 === 1'b1 && d1 === 1'b1)) begin
         extra_fail = 1;
         $display("FAIL watchdog: actual not done expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", c0 + c1 + extra_fail, f0 + f1 + extra_fail);
      $finish;
   end

endmodule